// File: doc/BRIEF.md
# Sized-Write General-Purpose Register File

This block holds sixteen 64-bit general-purpose registers behind one write port and two read ports. Every port carries a 4-bit register code, a flag telling whether an extension prefix was present, and a 2-bit access size. The register code is the extension bit on top of a 3-bit field. Codes 0 to 7 name the eight legacy registers in their architectural order. Codes 8 to 15 name the eight extended registers.

A write merges into the old contents or zero-extends over them, depending on its size. Byte writes reach either the low byte of a register or, with no prefix, the legacy high byte (bits 15:8) of one of the first four registers. Reads are combinational and return the selected field zero-extended to 64 bits. A high-byte read returns its byte shifted down to bits 7:0.

The ports are plain register-file strobes and have no valid/ready handshake. The write port never applies back-pressure: a write presented with `wr_en` high takes effect at the next rising clock edge. The read ports answer in the same cycle.

Top module: `gpr_merge_rf`

## Requirements
- R1: An active-low reset sets all sixteen registers to zero.
- R2: A byte write (size code 0) to a low byte replaces bits 7:0 of the target and leaves bits 63:8 unchanged.
- R3: A byte write with the prefix flag low and a register code of 4 to 7 changes only bits 15:8 of register (code minus 4).
- R4: With the prefix flag high, byte codes 4 to 7 select the low byte of registers 4 to 7, for both writes and reads.
- R5: A word write (size code 1) replaces bits 15:0 and leaves bits 63:16 unchanged.
- R6: A doubleword write (size code 2) places the value in bits 31:0 and clears bits 63:32.
- R7: A quadword write (size code 3) replaces all 64 bits.
- R8: Register code bit 3 is the extension bit. Codes 8 to 15 select eight registers that are separate from registers 0 to 7.
- R9: A read returns the field selected by its size, zero-extended to 64 bits. A high-byte read returns bits 15:8 in bits 7:0.
- R10: A read of the register being written in the same cycle returns the old value. The new value is visible after the clock edge.
- R11: With `wr_en` low, no register changes, whatever the other write inputs carry.
- R12: The two read ports select and size their accesses independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_code | input | 4 | Write register code (extension bit in bit 3) |
| wr_rex | input | 1 | Extension prefix present on the write |
| wr_size | input | 2 | Write size: 0 byte, 1 word, 2 doubleword, 3 quadword |
| wr_data | input | 64 | Write value; only the low bits needed by the size are used |
| rd_code | input | 2x4 | Register code for each read port |
| rd_rex | input | 2 | Extension prefix present for each read port |
| rd_size | input | 2x2 | Access size for each read port, same encoding as the write |
| rd_data | output | 2x64 | Zero-extended read result for each read port |

## Verification
On every cycle the assertions check the per-size merge rules of the write port against the register contents one cycle later: low-byte, high-byte, word, doubleword and quadword writes. They also check that nothing changes without a write, that reset clears the file, and that a quadword read on port 0 matches storage. The bench scenarios cover what the assertions cannot see: the mapping of codes to registers as seen through the ports, including the separation of high-byte and prefixed low-byte selection and of codes above 7. The scenarios also cover zero-extended narrow reads on both ports and the old-value result of a read that meets a write in the same cycle.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;

  localparam int GPR_CODE_W = 4;
  localparam int GPR_NREGS  = 1 << GPR_CODE_W;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_QWORD = 2'd3
  } gpr_size_e;

  typedef struct packed {
    logic [GPR_CODE_W-1:0] idx;   // physical register index
    logic                  hi;    // access targets bits 15:8
  } gpr_sel_t;

endpackage

// File: rtl/gpr_sel_decode.sv
`timescale 1ns/1ps
module gpr_sel_decode
  import gpr_pkg::*;
(
  input  logic [GPR_CODE_W-1:0] code,
  input  logic                  rex,
  input  logic [1:0]            size,
  output gpr_sel_t              sel
);

  logic legacy_hi;

  // Without a prefix, byte codes 4..7 name the high byte of registers 0..3.
  assign legacy_hi = (size == SZ_BYTE) && !rex && (code[3:2] == 2'b01);

  always_comb begin
    sel.hi  = legacy_hi;
    sel.idx = legacy_hi ? {2'b00, code[1:0]} : code;
  end

endmodule

// File: rtl/gpr_write_merge.sv
`timescale 1ns/1ps
module gpr_write_merge
  import gpr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wdata,
  input  logic [1:0]      size,
  input  logic            hi,
  output logic [XLEN-1:0] new_val
);

  localparam int BW = 8;
  localparam int WW = 16;
  localparam int DW = 32;

  always_comb begin
    new_val = old_val;
    unique case (size)
      SZ_BYTE: begin
        if (hi) new_val[WW-1:BW] = wdata[BW-1:0];
        else    new_val[BW-1:0]  = wdata[BW-1:0];
      end
      SZ_WORD:  new_val[WW-1:0] = wdata[WW-1:0];
      SZ_DWORD: begin
        new_val         = '0;
        new_val[DW-1:0] = wdata[DW-1:0];
      end
      default:  new_val = wdata;
    endcase
  end

endmodule

// File: rtl/gpr_read_extract.sv
`timescale 1ns/1ps
module gpr_read_extract
  import gpr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] reg_val,
  input  logic [1:0]      size,
  input  logic            hi,
  output logic [XLEN-1:0] rdata
);

  localparam int BW = 8;
  localparam int WW = 16;
  localparam int DW = 32;

  always_comb begin
    rdata = '0;
    unique case (size)
      SZ_BYTE: begin
        if (hi) rdata[BW-1:0] = reg_val[WW-1:BW];
        else    rdata[BW-1:0] = reg_val[BW-1:0];
      end
      SZ_WORD:  rdata[WW-1:0] = reg_val[WW-1:0];
      SZ_DWORD: rdata[DW-1:0] = reg_val[DW-1:0];
      default:  rdata = reg_val;
    endcase
  end

endmodule

// File: rtl/gpr_merge_rf.sv
`timescale 1ns/1ps
module gpr_merge_rf
  import gpr_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NUM_RD = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [GPR_CODE_W-1:0]               wr_code,
  input  logic                                wr_rex,
  input  logic [1:0]                          wr_size,
  input  logic [XLEN-1:0]                     wr_data,
  input  logic [NUM_RD-1:0][GPR_CODE_W-1:0]   rd_code,
  input  logic [NUM_RD-1:0]                   rd_rex,
  input  logic [NUM_RD-1:0][1:0]              rd_size,
  output logic [NUM_RD-1:0][XLEN-1:0]         rd_data
);

  localparam int NREGS = GPR_NREGS;

  logic [NREGS-1:0][XLEN-1:0] regs_q;

  gpr_sel_t        wsel;
  logic [XLEN-1:0] wmerged;

  gpr_sel_decode u_wdec (
    .code (wr_code),
    .rex  (wr_rex),
    .size (wr_size),
    .sel  (wsel)
  );

  gpr_write_merge #(.XLEN(XLEN)) u_merge (
    .old_val (regs_q[wsel.idx]),
    .wdata   (wr_data),
    .size    (wr_size),
    .hi      (wsel.hi),
    .new_val (wmerged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      regs_q[wsel.idx] <= wmerged;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_sel_t rsel;

    gpr_sel_decode u_rdec (
      .code (rd_code[p]),
      .rex  (rd_rex[p]),
      .size (rd_size[p]),
      .sel  (rsel)
    );

    gpr_read_extract #(.XLEN(XLEN)) u_ext (
      .reg_val (regs_q[rsel.idx]),
      .size    (rd_size[p]),
      .hi      (rsel.hi),
      .rdata   (rd_data[p])
    );
  end

endmodule

// File: rtl/gpr_merge_rf_chk.sv
`timescale 1ns/1ps
module gpr_merge_rf_chk
  import gpr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic [GPR_CODE_W-1:0]            wr_code,
  input logic                             wr_rex,
  input logic [1:0]                       wr_size,
  input logic [XLEN-1:0]                  wr_data,
  input logic [GPR_CODE_W-1:0]            rd_code0,
  input logic [1:0]                       rd_size0,
  input logic [XLEN-1:0]                  rd_data0,
  input logic [GPR_NREGS-1:0][XLEN-1:0]   regs_q
);

  logic [GPR_CODE_W-1:0] prev_code;
  logic [XLEN-1:0]       prev_val;
  logic [XLEN-1:0]       prev_hval;
  logic [XLEN-1:0]       now_val;
  logic [XLEN-1:0]       now_hval;
  logic                  lo_byte;
  logic                  hi_byte;

  // Snapshot of the addressed register one cycle back.
  always_ff @(posedge clk) begin
    prev_code <= wr_code;
    prev_val  <= regs_q[wr_code];
    prev_hval <= regs_q[{2'b00, wr_code[1:0]}];
  end

  assign now_val  = regs_q[prev_code];
  assign now_hval = regs_q[{2'b00, prev_code[1:0]}];
  assign hi_byte  = (wr_size == SZ_BYTE) && !wr_rex && (wr_code[3:2] == 2'b01);
  assign lo_byte  = (wr_size == SZ_BYTE) && !hi_byte;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (regs_q == '0));

  assert_byte_lo_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lo_byte) |=> (now_val[XLEN-1:8] == prev_val[XLEN-1:8]) &&
                           (now_val[7:0] == $past(wr_data[7:0])));

  assert_byte_hi_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hi_byte) |=> (now_hval[15:8] == $past(wr_data[7:0])) &&
                           (now_hval[7:0] == prev_hval[7:0]) &&
                           (now_hval[XLEN-1:16] == prev_hval[XLEN-1:16]));

  assert_word_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_WORD) |=> (now_val[XLEN-1:16] == prev_val[XLEN-1:16]) &&
                                      (now_val[15:0] == $past(wr_data[15:0])));

  assert_dword_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_DWORD) |=> (now_val[XLEN-1:32] == '0) &&
                                       (now_val[31:0] == $past(wr_data[31:0])));

  assert_qword_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_QWORD) |=> (now_val == $past(wr_data)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));

  assert_qword_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_size0 == SZ_QWORD) |-> (rd_data0 == regs_q[rd_code0]));

endmodule

bind gpr_merge_rf gpr_merge_rf_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_code  (wr_code),
  .wr_rex   (wr_rex),
  .wr_size  (wr_size),
  .wr_data  (wr_data),
  .rd_code0 (rd_code[0]),
  .rd_size0 (rd_size[0]),
  .rd_data0 (rd_data[0]),
  .regs_q   (regs_q)
);

// File: tb/gpr_merge_rf_tb.sv
`timescale 1ns/1ps
module gpr_merge_rf_tb;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [3:0]      wr_code = '0;
  logic            wr_rex = 1'b0;
  logic [1:0]      wr_size = '0;
  logic [63:0]     wr_data = '0;
  logic [1:0][3:0] rd_code = '0;
  logic [1:0]      rd_rex = '0;
  logic [1:0][1:0] rd_size = '0;
  logic [1:0][63:0] rd_data;

  int total = 0;
  int bad = 0;

  localparam logic [1:0] B = 2'd0, W = 2'd1, D = 2'd2, Q = 2'd3;

  always #5 clk = ~clk;

  gpr_merge_rf u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code), .wr_rex(wr_rex),
    .wr_size(wr_size), .wr_data(wr_data), .rd_code(rd_code), .rd_rex(rd_rex),
    .rd_size(rd_size), .rd_data(rd_data)
  );

  typedef struct packed {
    logic        wen;
    logic [3:0]  wc;
    logic        wx;
    logic [1:0]  ws;
    logic [63:0] wd;
    logic [3:0]  c0;
    logic        x0;
    logic [1:0]  s0;
    logic [63:0] e0;
    logic [3:0]  c1;
    logic        x1;
    logic [1:0]  s1;
    logic [63:0] e1;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    // R7 full quadword write
    '{1'b1, 4'd0, 1'b0, Q, 64'h1122334455667788, 4'd0, 1'b0, Q, 64'h1122334455667788, 4'd0, 1'b0, Q, 64'h1122334455667788, 8'd7},
    // R2 low byte merge
    '{1'b1, 4'd0, 1'b0, B, 64'hFFFFFFFFFFFFFFAA, 4'd0, 1'b0, Q, 64'h11223344556677AA, 4'd0, 1'b0, B, 64'h00000000000000AA, 8'd2},
    // R3 legacy high byte of register 0
    '{1'b1, 4'd4, 1'b0, B, 64'hFFFFFFFFFFFFFF55, 4'd0, 1'b0, Q, 64'h11223344556655AA, 4'd4, 1'b0, B, 64'h0000000000000055, 8'd3},
    // R11 idle write inputs, R9 high-byte read
    '{1'b0, 4'd2, 1'b0, Q, 64'hDEADBEEFDEADBEEF, 4'd4, 1'b0, B, 64'h0000000000000055, 4'd2, 1'b0, Q, 64'h0, 8'd11},
    // R5 word merge
    '{1'b1, 4'd0, 1'b0, W, 64'hFFFFFFFFFFFFBEEF, 4'd0, 1'b0, Q, 64'h112233445566BEEF, 4'd0, 1'b0, W, 64'h000000000000BEEF, 8'd5},
    // R6 doubleword clears upper half
    '{1'b1, 4'd0, 1'b0, D, 64'hFFFFFFFFCAFEF00D, 4'd0, 1'b0, Q, 64'h00000000CAFEF00D, 4'd0, 1'b0, D, 64'h00000000CAFEF00D, 8'd6},
    // R4 prefixed byte read of register 4, R12 dword read on port 1
    '{1'b1, 4'd4, 1'b1, Q, 64'h0123456789ABCDEF, 4'd4, 1'b1, B, 64'h00000000000000EF, 4'd4, 1'b0, D, 64'h0000000089ABCDEF, 8'd4},
    // R4 prefixed byte write to register 5, register 1 untouched
    '{1'b1, 4'd5, 1'b1, B, 64'h9999999999999977, 4'd5, 1'b0, Q, 64'h0000000000000077, 4'd1, 1'b0, Q, 64'h0, 8'd4},
    // R8 extended code 9
    '{1'b1, 4'd9, 1'b1, Q, 64'hA5A5000000005A5A, 4'd9, 1'b1, Q, 64'hA5A5000000005A5A, 4'd1, 1'b0, Q, 64'h0, 8'd8},
    // R8 extended code 12, register 4 untouched
    '{1'b1, 4'd12, 1'b1, B, 64'h111111111111113C, 4'd12, 1'b1, Q, 64'h000000000000003C, 4'd4, 1'b1, Q, 64'h0123456789ABCDEF, 8'd8},
    // R9 high-byte read shifted down, dword read zero-extended
    '{1'b0, 4'd0, 1'b0, B, 64'h0, 4'd4, 1'b0, B, 64'h00000000000000F0, 4'd9, 1'b1, D, 64'h0000000000005A5A, 8'd9}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic set_rd(input int p, input logic [3:0] c, input logic x, input logic [1:0] s);
    rd_code[p] = c;
    rd_rex[p]  = x;
    rd_size[p] = s;
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    set_rd(0, 4'd3, 1'b0, Q);
    set_rd(1, 4'd15, 1'b1, Q);
    #1;
    check("R1 reg3 after reset", rd_data[0], 64'h0);
    check("R1 reg15 after reset", rd_data[1], 64'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en   = TBL[i].wen;
      wr_code = TBL[i].wc;
      wr_rex  = TBL[i].wx;
      wr_size = TBL[i].ws;
      wr_data = TBL[i].wd;
      set_rd(0, TBL[i].c0, TBL[i].x0, TBL[i].s0);
      set_rd(1, TBL[i].c1, TBL[i].x1, TBL[i].s1);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      check($sformatf("R%0d vec%0d port0", TBL[i].req, i), rd_data[0], TBL[i].e0);
      check($sformatf("R%0d vec%0d port1 (R12)", TBL[i].req, i), rd_data[1], TBL[i].e1);
    end

    // R10 read during write sees the old value, new value after the edge
    @(negedge clk);
    wr_en = 1'b1; wr_code = 4'd7; wr_rex = 1'b0; wr_size = Q; wr_data = 64'h0000000000005555;
    set_rd(0, 4'd7, 1'b0, Q);
    #1;
    check("R10 old value before edge", rd_data[0], 64'h0);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    check("R10 new value after edge", rd_data[0], 64'h0000000000005555);

    // R11 write inputs without strobe leave register 7 alone
    @(negedge clk);
    wr_en = 1'b0; wr_code = 4'd7; wr_size = Q; wr_data = 64'hFFFFFFFFFFFFFFFF;
    @(posedge clk);
    #1;
    check("R11 no strobe no change", rd_data[0], 64'h0000000000005555);

    // R1 reset in mid-run clears written registers
    @(negedge clk);
    rst_n = 1'b0;
    set_rd(0, 4'd0, 1'b0, Q);
    set_rd(1, 4'd4, 1'b1, Q);
    @(posedge clk);
    #1;
    check("R1 reg0 cleared", rd_data[0], 64'h0);
    check("R1 reg4 cleared", rd_data[1], 64'h0);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule